// File: doc/BRIEF.md
# Transmit DMA Channel Control and Quiesce Logic

This block holds the per-channel control and status state of a transmit DMA engine. Software reaches it through a 64-bit register port. Every access names a channel index and a register offset. For each channel the block keeps a run-enable bit and a self-clearing soft-reset bit. It also keeps a read-only quiesce flag, which software polls to learn when a stop or a soft reset has taken effect.

Each channel also has a one-shot mailbox-request flag and a mailbox address written in two halves. An event mask register completes the per-channel state.

On the engine side, each channel supplies an idle indication and a mailbox-completion pulse. The block drives the channel enable, the pending mailbox request, the assembled mailbox address and the event mask. A stop and a soft reset both finish through the same quiesce flag. That flag rises only after the engine has reported idle on two consecutive cycles while the channel is disabled.

Top module: `txdma_chan_ctrl`

## Requirements
- R1: After the reset input (active low), every channel has enable 0, mailbox request 0, mailbox address 0 and event mask all ones.
- R2: A write to the configuration register (offset 0) with bit 0 set and bit 1 clear sets the channel enable at that clock edge. At the same edge the quiesce flag (configuration bit 2) clears, and it stays 0 while enabled.
- R3: After enable is cleared, the quiesce flag stays 0 while the engine's idle input is low. The flag becomes 1 at the second consecutive clock edge at which idle is sampled high.
- R4: A configuration write with bit 1 set forces enable to 0, whatever bit 0 holds, and clears the quiesce flag. Bit 1 reads back as 1 only in the cycle after that write. Mailbox and mask state are kept.
- R5: After a soft reset, the quiesce flag returns to 1 only after two consecutive idle edges that follow the reset write.
- R6: Writing the status register (offset 1) with bit 0 set arms the mailbox request. Writing it with bit 0 clear has no effect on the request.
- R7: A mailbox-done pulse clears an armed request. A status write with bit 0 set in the same cycle as mailbox-done takes priority, and the request stays armed.
- R8: The low mailbox address register (offset 2) and the high one (offset 3) are written separately. The address output equals (high << 32) | low, and only the low 12 bits of a high-register write are kept.
- R9: The event mask register (offset 4) reads back what was last written.
- R10: An access whose channel index is at or above the channel count returns the error flag and read data 0. It changes no channel state.
- R11: Every request produces a response one cycle later. A read of an unused offset (5 to 7) returns 0 with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_chan | input | 3 | Channel index |
| req_reg | input | 3 | Register offset |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Channel index out of range |
| rsp_rdata | output | 64 | Read data |
| eng_idle | input | 4 | Per-channel engine idle indication |
| mbox_done | input | 4 | Per-channel mailbox update finished |
| chan_enable | output | 4 | Per-channel run enable |
| mbox_req | output | 4 | Per-channel mailbox update pending |
| mbox_addr | output | 176 | Per-channel 44-bit mailbox address, channel i at bits [44*i +: 44] |
| int_mask | output | 32 | Per-channel 8-bit event mask, channel i at bits [8*i +: 8] |

## Verification
On every cycle, the assertions check the following:
- a rising quiesce flag is always preceded by two idle samples with the channel disabled;
- an enabled channel never shows quiesce;
- the soft-reset cycle always shows enable and quiesce low;
- a mailbox request only falls after a done pulse;
- every request gets a response, and error responses carry zero data.

Only the bench's scenarios can show the rest:
- the exact edge at which quiesce rises after a stop or a reset;
- that mask and mailbox state survive a soft reset;
- write priority over done;
- the truncation of the high address;
- the fact that writes to a bad channel leave every channel untouched.

// File: rtl/txdma_ctl_pkg.sv
package txdma_ctl_pkg;
    localparam int OFF_W = 3;

    typedef enum logic [OFF_W-1:0] {
        REG_CFG    = 3'd0,
        REG_STAT   = 3'd1,
        REG_MBX_LO = 3'd2,
        REG_MBX_HI = 3'd3,
        REG_IMASK  = 3'd4
    } reg_sel_e;

    // Bit positions software decodes
    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_RST_BIT  = 1;
    localparam int CFG_QST_BIT  = 2;
    localparam int STAT_ARM_BIT = 0;
endpackage

// File: rtl/txdma_req_decode.sv
module txdma_req_decode #(
    parameter int NUM_CH   = 4,
    parameter int CH_IDX_W = 3
) (
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [CH_IDX_W-1:0] req_chan,
    output logic                chan_ok,
    output logic [NUM_CH-1:0]   wr_sel
);
    localparam int PAD_W = 32 - CH_IDX_W;

    assign chan_ok = ({{PAD_W{1'b0}}, req_chan} < NUM_CH);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        assign wr_sel[i] = req_valid && req_write && chan_ok &&
                           (req_chan == CH_IDX_W'(i));
    end
endmodule

// File: rtl/txdma_chan_regs.sv
module txdma_chan_regs
    import txdma_ctl_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LO_W   = 32,
    parameter int HI_W   = 12,
    parameter int MASK_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [OFF_W-1:0]     wr_off,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [OFF_W-1:0]     rd_off,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 eng_idle,
    input  logic                 mbox_done,
    output logic                 enable,
    output logic                 mbox_req,
    output logic [LO_W+HI_W-1:0] mbox_addr,
    output logic [MASK_W-1:0]    int_mask
);
    typedef struct packed {
        logic              enable;
        logic              rst_pulse;
        logic              quiesce;
        logic              idle_seen;
        logic              arm;
        logic [LO_W-1:0]   lo;
        logic [HI_W-1:0]   hi;
        logic [MASK_W-1:0] mask;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic wr_cfg, wr_stat, soft_rst;

    always_comb begin
        st_d     = st_q;
        wr_cfg   = wr_en && (wr_off == REG_CFG);
        wr_stat  = wr_en && (wr_off == REG_STAT);
        soft_rst = wr_cfg && wr_data[CFG_RST_BIT];

        st_d.rst_pulse = soft_rst;
        if (wr_cfg)
            st_d.enable = soft_rst ? 1'b0 : wr_data[CFG_EN_BIT];

        // Two consecutive idle samples, restarted by a soft reset
        st_d.idle_seen = eng_idle && !soft_rst;
        if (st_d.enable || soft_rst)
            st_d.quiesce = 1'b0;
        else if (eng_idle && st_q.idle_seen)
            st_d.quiesce = 1'b1;

        if (wr_stat && wr_data[STAT_ARM_BIT])
            st_d.arm = 1'b1;
        else if (mbox_done)
            st_d.arm = 1'b0;

        if (wr_en && wr_off == REG_MBX_LO) st_d.lo   = wr_data[LO_W-1:0];
        if (wr_en && wr_off == REG_MBX_HI) st_d.hi   = wr_data[HI_W-1:0];
        if (wr_en && wr_off == REG_IMASK)  st_d.mask = wr_data[MASK_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_off)
            REG_CFG: begin
                rd_data[CFG_EN_BIT]  = st_q.enable;
                rd_data[CFG_RST_BIT] = st_q.rst_pulse;
                rd_data[CFG_QST_BIT] = st_q.quiesce;
            end
            REG_STAT:   rd_data[STAT_ARM_BIT] = st_q.arm;
            REG_MBX_LO: rd_data[LO_W-1:0]     = st_q.lo;
            REG_MBX_HI: rd_data[HI_W-1:0]     = st_q.hi;
            REG_IMASK:  rd_data[MASK_W-1:0]   = st_q.mask;
            default:    rd_data = '0;
        endcase
    end

    assign enable    = st_q.enable;
    assign mbox_req  = st_q.arm;
    assign mbox_addr = {st_q.hi, st_q.lo};
    assign int_mask  = st_q.mask;

    logic unused_wdata;
    assign unused_wdata = ^wr_data;

    // R3: quiesce only rises after two idle samples with the channel disabled
    assert_quiesce_after_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.quiesce) |-> ($past(eng_idle) && $past(eng_idle, 2) && !st_q.enable));

    // R2: an enabled channel never reports quiesce
    assert_enabled_not_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.enable |-> !st_q.quiesce);

    // R4: the soft-reset cycle shows the channel stopped and not quiesced
    assert_reset_clears_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst_pulse |-> (!st_q.enable && !st_q.quiesce));

    // R7: a pending mailbox request falls only after a done pulse
    assert_mbox_clear_by_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.arm) |-> $past(mbox_done));
endmodule

// File: rtl/txdma_chan_ctrl.sv
module txdma_chan_ctrl
    import txdma_ctl_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int CH_IDX_W = 3,
    parameter int DATA_W   = 64,
    parameter int LO_W     = 32,
    parameter int HI_W     = 12,
    parameter int MASK_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [CH_IDX_W-1:0]        req_chan,
    input  logic [OFF_W-1:0]           req_reg,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       rsp_valid,
    output logic                       rsp_err,
    output logic [DATA_W-1:0]          rsp_rdata,
    input  logic [NUM_CH-1:0]          eng_idle,
    input  logic [NUM_CH-1:0]          mbox_done,
    output logic [NUM_CH-1:0]          chan_enable,
    output logic [NUM_CH-1:0]          mbox_req,
    output logic [NUM_CH*(LO_W+HI_W)-1:0] mbox_addr,
    output logic [NUM_CH*MASK_W-1:0]   int_mask
);
    localparam int ADDR_W = LO_W + HI_W;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] data;
    } rsp_t;

    logic              chan_ok;
    logic [NUM_CH-1:0] wr_sel;
    logic [DATA_W-1:0] rd_all [NUM_CH];
    logic [DATA_W-1:0] rd_sel;
    rsp_t              rsp_d, rsp_q;

    txdma_req_decode #(.NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_chan  (req_chan),
        .chan_ok   (chan_ok),
        .wr_sel    (wr_sel)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        txdma_chan_regs #(
            .DATA_W (DATA_W),
            .LO_W   (LO_W),
            .HI_W   (HI_W),
            .MASK_W (MASK_W)
        ) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_sel[i]),
            .wr_off    (req_reg),
            .wr_data   (req_wdata),
            .rd_off    (req_reg),
            .rd_data   (rd_all[i]),
            .eng_idle  (eng_idle[i]),
            .mbox_done (mbox_done[i]),
            .enable    (chan_enable[i]),
            .mbox_req  (mbox_req[i]),
            .mbox_addr (mbox_addr[i*ADDR_W +: ADDR_W]),
            .int_mask  (int_mask[i*MASK_W +: MASK_W])
        );
    end

    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (req_chan == CH_IDX_W'(i)) rd_sel = rd_sel | rd_all[i];
        rsp_d.valid = req_valid;
        rsp_d.err   = req_valid && !chan_ok;
        rsp_d.data  = (req_valid && !req_write && chan_ok) ? rd_sel : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.data;

    // R11: every request is answered on the following cycle
    assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10: a rejected access never returns data
    assert_bad_chan_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));
endmodule

// File: tb/txdma_chan_ctrl_test.sv
module txdma_chan_ctrl_test;
    localparam int ADDR_W = 44;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [2:0]  req_chan = '0, req_reg = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic [3:0]  eng_idle = 4'hF, mbox_done = 4'h0;
    logic [3:0]  chan_enable, mbox_req;
    logic [4*ADDR_W-1:0] mbox_addr;
    logic [31:0] int_mask;

    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    txdma_chan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_chan(req_chan), .req_reg(req_reg), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .eng_idle(eng_idle), .mbox_done(mbox_done), .chan_enable(chan_enable),
        .mbox_req(mbox_req), .mbox_addr(mbox_addr), .int_mask(int_mask)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge
    task automatic wr(input int ch, input int off, input logic [63:0] d);
        req_valid = 1'b1; req_write = 1'b1;
        req_chan = ch[2:0]; req_reg = off[2:0]; req_wdata = d;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input int ch, input int off, output logic [63:0] d, output logic e);
        req_valid = 1'b1; req_write = 1'b0;
        req_chan = ch[2:0]; req_reg = off[2:0];
        @(posedge clk); @(negedge clk);
        d = rsp_rdata; e = rsp_err;
        chk("R11 rsp_valid", 64'(rsp_valid), 64'd1);
        req_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [63:0] d; logic e;
        chk("R1 enable", 64'(chan_enable), 64'h0);
        chk("R1 mbox_req", 64'(mbox_req), 64'h0);
        chk("R1 mbox_addr ch3", 64'(mbox_addr[3*ADDR_W +: ADDR_W]), 64'h0);
        chk("R1 int_mask", 64'(int_mask), 64'hFFFF_FFFF);
        @(negedge clk);
        rd(1, 4, d, e);
        chk("R1 mask read", d, 64'hFF);
    endtask

    task automatic t_enable();
        logic [63:0] d; logic e;
        rd(0, 0, d, e);
        chk("R5 idle quiesce", d, 64'h4);
        wr(0, 0, 64'h1);
        chk("R2 chan_enable", 64'(chan_enable[0]), 64'd1);
        rd(0, 0, d, e);
        chk("R2 cfg read", d, 64'h1);
    endtask

    task automatic t_stop();
        logic [63:0] d; logic e;
        eng_idle[0] = 1'b0;
        wr(0, 0, 64'h0);
        chk("R3 enable low", 64'(chan_enable[0]), 64'd0);
        repeat (5) @(negedge clk);
        rd(0, 0, d, e);
        chk("R3 busy no quiesce", d, 64'h0);
        eng_idle[0] = 1'b1;
        @(negedge clk);
        rd(0, 0, d, e);
        chk("R3 one idle edge", d, 64'h0);
        rd(0, 0, d, e);
        chk("R3 quiesce set", d, 64'h4);
    endtask

    task automatic t_soft_reset();
        logic [63:0] d; logic e;
        wr(1, 4, 64'h5A);
        wr(1, 2, 64'h1234);
        wr(1, 0, 64'h1);
        chk("R2 ch1 enable", 64'(chan_enable[1]), 64'd1);
        wr(1, 0, 64'h3);
        chk("R4 enable forced low", 64'(chan_enable[1]), 64'd0);
        rd(1, 0, d, e);
        chk("R4 reset bit pulse", d, 64'h2);
        rd(1, 0, d, e);
        chk("R5 not yet quiesced", d, 64'h0);
        rd(1, 0, d, e);
        chk("R5 quiesce after reset", d, 64'h4);
        rd(1, 4, d, e);
        chk("R4 mask kept", d, 64'h5A);
        rd(1, 2, d, e);
        chk("R4 mbox low kept", d, 64'h1234);
    endtask

    task automatic t_mailbox();
        logic [63:0] d; logic e;
        wr(2, 1, 64'h1);
        chk("R6 arm", 64'(mbox_req[2]), 64'd1);
        wr(2, 1, 64'h0);
        chk("R6 zero write ignored", 64'(mbox_req[2]), 64'd1);
        mbox_done[2] = 1'b1;
        @(posedge clk); @(negedge clk);
        mbox_done[2] = 1'b0;
        chk("R7 done clears", 64'(mbox_req[2]), 64'd0);
        wr(2, 1, 64'h1);
        mbox_done[2] = 1'b1;
        wr(2, 1, 64'h1);
        mbox_done[2] = 1'b0;
        chk("R7 write wins", 64'(mbox_req[2]), 64'd1);
        rd(2, 1, d, e);
        chk("R7 stat read", d, 64'h1);
    endtask

    task automatic t_mbox_addr();
        logic [63:0] d; logic e;
        wr(3, 2, 64'hDEAD_BEEF);
        chk("R8 low only", 64'(mbox_addr[3*ADDR_W +: ADDR_W]), 64'hDEAD_BEEF);
        wr(3, 3, 64'hFFFF_FABC);
        chk("R8 full addr", 64'(mbox_addr[3*ADDR_W +: ADDR_W]), 64'hABC_DEAD_BEEF);
        rd(3, 3, d, e);
        chk("R8 high read", d, 64'hABC);
    endtask

    task automatic t_mask();
        logic [63:0] d; logic e;
        wr(2, 4, 64'h00);
        chk("R9 mask out", 64'(int_mask[2*8 +: 8]), 64'h0);
        wr(2, 4, 64'hC3);
        rd(2, 4, d, e);
        chk("R9 mask read", d, 64'hC3);
    endtask

    task automatic t_bad_access();
        logic [63:0] d; logic e;
        logic [3:0] en_before;
        en_before = chan_enable;
        wr(5, 0, 64'h1);
        chk("R10 write err", 64'(rsp_err), 64'd1);
        chk("R10 no enable change", 64'(chan_enable), 64'(en_before));
        wr(4, 4, 64'h0);
        rd(2, 4, d, e);
        chk("R10 ch2 mask untouched", d, 64'hC3);
        rd(6, 0, d, e);
        chk("R10 read err", 64'(e), 64'd1);
        chk("R10 read data zero", d, 64'h0);
        rd(0, 7, d, e);
        chk("R11 unused offset data", d, 64'h0);
        chk("R11 unused offset err", 64'(e), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset_state();
        t_enable();
        t_stop();
        t_soft_reset();
        t_mailbox();
        t_mbox_addr();
        t_mask();
        t_bad_access();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule